// File: doc/BRIEF.md
# Loop Stream Detector

This block sits beside a micro-op queue and looks for short loops in the decoded micro-op stream. When a taken branch jumps backward to the same target on two back-to-back passes, the block records the body of the next pass. While recording, it checks whether the loop is small and simple enough to be replayed from the queue alone. If the loop passes those checks, the block replays the recorded micro-ops in a cycle-by-cycle loop. During replay it also holds a sleep indication high so that the fetch and decode stages can power down.

A branch misprediction ends replay, or ends a recording that is in progress. The loop target that was learned is kept, so the same loop can lock again after one more pass. A flush discards both the recorded body and the learned target. Input micro-ops carry these flags: taken branch, call/return, stack push, stack pop, start of a new 32-byte code chunk, and residency in the decoded micro-op cache.

Top module: `lsd_top`

## Requirements
- R1: In the idle state, a valid taken micro-op whose target is at or below its own address (a backward branch) becomes the loop candidate and replaces any earlier candidate. A taken branch with a target above its address changes nothing. A backward branch whose target equals the held candidate starts a capture, and the capture begins with the next valid micro-op.
- R2: A capture ends on a backward taken micro-op whose target equals the candidate. If the body qualifies, out_valid and fe_sleep both go high on the following cycle, and the first captured micro-op is presented first.
- R3: While streaming, the captured payloads are presented in capture order, one per cycle. out_last is high on the loop-closing micro-op, and the next cycle returns to the first entry.
- R4: A body of at most 64 micro-ops (closing branch included) may qualify. A 65th micro-op rejects it.
- R5: A body may qualify only if it holds at most 8 taken micro-ops, the closing branch included.
- R6: A body may qualify only if it spans at most 8 chunks. The first captured micro-op counts as one chunk, and each later micro-op flagged as starting a new chunk adds one.
- R7: Every captured micro-op must be flagged as resident in the micro-op cache, or the body is rejected.
- R8: Any captured micro-op flagged as a call or return rejects the body.
- R9: The number of push flags must equal the number of pop flags over the body, or the body is rejected. A rejection also drops the candidate.
- R10: A mispredict input ends streaming or capture, so out_valid and fe_sleep are low on the next cycle. The candidate target is kept, so one further closing branch to it restarts capture.
- R11: A flush input clears the captured body and the candidate and returns the block to idle. Two more closing branches are then needed before a capture starts.
- R12: Valid micro-ops that arrive during streaming, or in a cycle with mispredict or flush asserted, are ignored. Streaming continues unaffected until mispredict or flush.
- R13: After reset the block is idle: out_valid, fe_sleep and out_last are low and out_payload is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming micro-op present |
| in_pc | input | 16 | Address of the micro-op's instruction |
| in_target | input | 16 | Branch target when in_taken is set |
| in_payload | input | 16 | Opaque micro-op contents |
| in_taken | input | 1 | Micro-op is a taken branch |
| in_call_ret | input | 1 | Micro-op is a call or return |
| in_push | input | 1 | Micro-op pushes to the stack |
| in_pop | input | 1 | Micro-op pops from the stack |
| in_chunk_start | input | 1 | Micro-op begins a new 32-byte chunk |
| in_resident | input | 1 | Micro-op is present in the decoded micro-op cache |
| mispredict | input | 1 | Branch misprediction, ends replay |
| flush | input | 1 | Pipeline flush, clears all loop state |
| out_valid | output | 1 | Replayed micro-op present |
| out_payload | output | 16 | Replayed micro-op contents |
| out_last | output | 1 | Replayed micro-op is the loop-closing branch |
| fe_sleep | output | 1 | Front end may sleep |

## Verification
Two events can coincide in one cycle: the arrival of the loop-closing branch that would lock the loop, and a misprediction or flush. The bench provokes this by raising mispredict in the same cycle as the closing micro-op of a qualifying body. The expected result is that streaming does not start and the candidate survives. The next closing pass must then begin a new capture, and the pass after that must lock. A reference model, written as queues and counters, predicts every output on every cycle, including micro-ops presented while streaming is already running.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    localparam int ADDR_W = 16;
    localparam int PAY_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_STREAM  = 2'd2
    } lsd_state_e;

    typedef struct packed {
        logic taken;
        logic call_ret;
        logic push;
        logic pop;
        logic chunk_start;
        logic resident;
    } uop_flags_t;

    typedef struct packed {
        logic [PAY_W-1:0] payload;
    } entry_t;

    function automatic logic is_backward(input logic [ADDR_W-1:0] pc,
                                         input logic [ADDR_W-1:0] tgt);
        return tgt <= pc;
    endfunction

endpackage

// File: rtl/lsd_detect.sv
module lsd_detect
    import lsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              taken,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    output logic              arm,
    output logic [ADDR_W-1:0] cand_tgt
);

    logic cand_vld;
    logic back;

    always_comb begin
        back = sample && taken && is_backward(pc, target);
        arm  = back && cand_vld && (target == cand_tgt);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cand_vld <= 1'b0;
            cand_tgt <= '0;
        end else if (back && !arm) begin
            cand_vld <= 1'b1;
            cand_tgt <= target;
        end
    end

endmodule

// File: rtl/lsd_rules.sv
module lsd_rules
    import lsd_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int MAX_TAKEN  = 8,
    parameter int MAX_CHUNKS = 8,
    parameter int CNT_W      = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             acc,
    input  uop_flags_t       fl,
    output logic [CNT_W-1:0] n_uop,
    output logic             qualify,
    output logic             overflow
);

    logic [CNT_W-1:0] n_taken, n_chunk;
    logic [CNT_W:0]   bal;
    logic             bad;

    logic [CNT_W-1:0] nu, nt, nc;
    logic [CNT_W:0]   nb;
    logic             nbad;

    always_comb begin
        nu   = n_uop + CNT_W'(1);
        nt   = n_taken + CNT_W'(fl.taken);
        nc   = n_chunk + CNT_W'(fl.chunk_start || (n_uop == '0));
        nb   = bal + (CNT_W+1)'(fl.push) - (CNT_W+1)'(fl.pop);
        nbad = bad || fl.call_ret || !fl.resident;
        qualify = (nu <= CNT_W'(DEPTH)) && (nt <= CNT_W'(MAX_TAKEN)) &&
                  (nc <= CNT_W'(MAX_CHUNKS)) && (nb == '0) && !nbad;
        overflow = nu > CNT_W'(DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            n_uop   <= '0;
            n_taken <= '0;
            n_chunk <= '0;
            bal     <= '0;
            bad     <= 1'b0;
        end else if (acc) begin
            n_uop   <= nu;
            n_taken <= nt;
            n_chunk <= nc;
            bal     <= nb;
            bad     <= nbad;
        end
    end

endmodule

// File: rtl/lsd_buffer.sv
module lsd_buffer
    import lsd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  entry_t           wdata,
    input  logic             lock,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             advance,
    output entry_t           rdata,
    output logic             last_hit
);

    entry_t           mem [DEPTH];
    logic [IDX_W-1:0] rd_ptr;
    logic [IDX_W-1:0] last_ptr;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            last_ptr <= '0;
        end else if (lock) begin
            rd_ptr   <= '0;
            last_ptr <= last_idx;
        end else if (advance) begin
            rd_ptr <= (rd_ptr == last_ptr) ? '0 : rd_ptr + IDX_W'(1);
        end
    end

    always_comb begin
        rdata    = mem[rd_ptr];
        last_hit = (rd_ptr == last_ptr);
    end

endmodule

// File: rtl/lsd_top.sv
module lsd_top
    import lsd_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int MAX_TAKEN  = 8,
    parameter int MAX_CHUNKS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [ADDR_W-1:0] in_target,
    input  logic [PAY_W-1:0]  in_payload,
    input  logic              in_taken,
    input  logic              in_call_ret,
    input  logic              in_push,
    input  logic              in_pop,
    input  logic              in_chunk_start,
    input  logic              in_resident,
    input  logic              mispredict,
    input  logic              flush,
    output logic              out_valid,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_last,
    output logic              fe_sleep
);

    localparam int CNT_W = $clog2(DEPTH + 2);
    localparam int IDX_W = $clog2(DEPTH);

    lsd_state_e        state, state_nx;
    logic              normal, sample, acc, close, lock, reject;
    logic              arm, qualify, overflow, last_hit;
    logic [ADDR_W-1:0] cand_tgt;
    logic [CNT_W-1:0]  cap_cnt;
    uop_flags_t        flags;
    entry_t            wentry, rentry;

    always_comb begin
        flags.taken       = in_taken;
        flags.call_ret    = in_call_ret;
        flags.push        = in_push;
        flags.pop         = in_pop;
        flags.chunk_start = in_chunk_start;
        flags.resident    = in_resident;
        wentry.payload    = in_payload;

        normal = in_valid && !flush && !mispredict;
        sample = normal && (state == ST_IDLE);
        acc    = normal && (state == ST_CAPTURE);
        close  = acc && in_taken && is_backward(in_pc, in_target) &&
                 (in_target == cand_tgt);
        lock   = close && qualify;
        reject = (close && !qualify) || (acc && !close && overflow);
    end

    always_comb begin
        state_nx = state;
        if (flush || mispredict) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (arm) state_nx = ST_CAPTURE;
                ST_CAPTURE: if (lock) state_nx = ST_STREAM;
                            else if (reject) state_nx = ST_IDLE;
                default:    state_nx = ST_STREAM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    lsd_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .clear    (flush || reject),
        .sample   (sample),
        .taken    (in_taken),
        .pc       (in_pc),
        .target   (in_target),
        .arm      (arm),
        .cand_tgt (cand_tgt)
    );

    lsd_rules #(
        .DEPTH      (DEPTH),
        .MAX_TAKEN  (MAX_TAKEN),
        .MAX_CHUNKS (MAX_CHUNKS),
        .CNT_W      (CNT_W)
    ) u_rules (
        .clk      (clk),
        .rst      (rst),
        .start    (arm),
        .acc      (acc),
        .fl       (flags),
        .n_uop    (cap_cnt),
        .qualify  (qualify),
        .overflow (overflow)
    );

    lsd_buffer #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_buffer (
        .clk      (clk),
        .rst      (rst),
        .we       (acc && (cap_cnt < CNT_W'(DEPTH))),
        .waddr    (cap_cnt[IDX_W-1:0]),
        .wdata    (wentry),
        .lock     (lock),
        .last_idx (cap_cnt[IDX_W-1:0]),
        .advance  ((state == ST_STREAM) && !flush && !mispredict),
        .rdata    (rentry),
        .last_hit (last_hit)
    );

    always_comb begin
        out_valid   = (state == ST_STREAM);
        fe_sleep    = (state == ST_STREAM);
        out_payload = out_valid ? rentry.payload : '0;
        out_last    = out_valid && last_hit;
    end

endmodule

// File: rtl/lsd_top_chk.sv
module lsd_top_chk
    import lsd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             mispredict,
    input logic             flush,
    input logic             out_valid,
    input logic             fe_sleep,
    input lsd_state_e       state,
    input logic [CNT_W-1:0] cap_cnt
);

    // R10: a misprediction wakes the front end on the next cycle
    a_r10_mispredict_wakes: assert property (@(posedge clk) disable iff (rst)
        mispredict |=> (!fe_sleep && !out_valid));

    // R11: a flush always lands in idle
    a_r11_flush_idles: assert property (@(posedge clk) disable iff (rst)
        flush |=> (state == ST_IDLE));

    // R12: streaming only stops on mispredict or flush
    a_r12_stream_holds: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mispredict && !flush) |=> out_valid);

    // R2: streaming can only begin straight out of a capture
    a_r2_lock_from_capture: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(state) == ST_CAPTURE));

    // R4: the capture count never passes the body limit
    a_r4_capture_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPTURE) |-> (cap_cnt <= CNT_W'(DEPTH)));

endmodule

bind lsd_top lsd_top_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mispredict (mispredict),
    .flush      (flush),
    .out_valid  (out_valid),
    .fe_sleep   (fe_sleep),
    .state      (state),
    .cap_cnt    (cap_cnt)
);

// File: tb/lsd_top_test.sv
module lsd_top_test;
    import lsd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int MAX_TAKEN  = 8;
    localparam int MAX_CHUNKS = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid, in_taken, in_call_ret, in_push, in_pop;
    logic              in_chunk_start, in_resident, mispredict, flush;
    logic [ADDR_W-1:0] in_pc, in_target;
    logic [PAY_W-1:0]  in_payload;
    logic              out_valid, out_last, fe_sleep;
    logic [PAY_W-1:0]  out_payload;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int                m_state;  // 0 idle, 1 capture, 2 stream
    bit                m_cv;
    logic [ADDR_W-1:0] m_cand;
    logic [PAY_W-1:0]  m_body[$];
    int                m_rd, m_taken, m_chunks, m_bal;
    bit                m_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsd_top #(.DEPTH(DEPTH), .MAX_TAKEN(MAX_TAKEN), .MAX_CHUNKS(MAX_CHUNKS)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pc(in_pc),
        .in_target(in_target), .in_payload(in_payload), .in_taken(in_taken),
        .in_call_ret(in_call_ret), .in_push(in_push), .in_pop(in_pop),
        .in_chunk_start(in_chunk_start), .in_resident(in_resident),
        .mispredict(mispredict), .flush(flush), .out_valid(out_valid),
        .out_payload(out_payload), .out_last(out_last), .fe_sleep(fe_sleep)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit back;
        bit ok;
        if (flush) begin
            m_state = 0; m_cv = 0; m_body.delete();
        end else if (mispredict) begin
            m_state = 0;
        end else if (m_state == 2) begin
            m_rd = (m_rd == m_body.size() - 1) ? 0 : m_rd + 1;
        end else if (in_valid) begin
            back = in_taken && (in_target <= in_pc);
            if (m_state == 0) begin
                if (back) begin
                    if (m_cv && in_target == m_cand) begin
                        m_state = 1; m_body.delete();
                        m_taken = 0; m_chunks = 0; m_bal = 0; m_bad = 0;
                    end else begin
                        m_cv = 1; m_cand = in_target;
                    end
                end
            end else begin
                m_body.push_back(in_payload);
                m_taken += int'(in_taken);
                if (m_body.size() == 1 || in_chunk_start) m_chunks++;
                m_bal += int'(in_push) - int'(in_pop);
                m_bad = m_bad || in_call_ret || !in_resident;
                if (back && in_target == m_cand) begin
                    ok = (m_body.size() <= DEPTH) && (m_taken <= MAX_TAKEN) &&
                         (m_chunks <= MAX_CHUNKS) && (m_bal == 0) && !m_bad;
                    if (ok) begin m_state = 2; m_rd = 0; end
                    else begin m_state = 0; m_cv = 0; end
                end else if (m_body.size() > DEPTH) begin
                    m_state = 0; m_cv = 0;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        bit               ev;
        logic [PAY_W-1:0] ep;
        bit               el;
        ev = (m_state == 2);
        ep = ev ? m_body[m_rd] : '0;
        el = ev && (m_rd == m_body.size() - 1);
        check(out_valid == ev, tag, "out_valid", int'(out_valid), int'(ev));
        check(fe_sleep == ev, tag, "fe_sleep", int'(fe_sleep), int'(ev));
        check(out_payload == ep, tag, "out_payload", int'(out_payload), int'(ep));
        check(out_last == el, tag, "out_last", int'(out_last), int'(el));
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_in();
        in_valid = 0; in_taken = 0; in_call_ret = 0; in_push = 0; in_pop = 0;
        in_chunk_start = 0; in_resident = 1; mispredict = 0; flush = 0;
        in_pc = '0; in_target = '0; in_payload = '0;
    endtask

    task automatic idle(input int n, input string tag);
        clear_in();
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_flush(input string tag);
        clear_in(); flush = 1; step(tag); flush = 0;
    endtask

    task automatic do_mispredict(input string tag);
        clear_in(); mispredict = 1; step(tag); mispredict = 0;
    endtask

    task automatic send_one(input int pc, input int tgt, input bit taken, input string tag);
        clear_in();
        in_valid = 1; in_pc = ADDR_W'(pc); in_target = ADDR_W'(tgt);
        in_taken = taken; in_payload = PAY_W'(pc ^ 16'h5A5A);
        step(tag);
        clear_in();
    endtask

    // one pass over a loop body; the last micro-op branches back to base
    task automatic loop_iter(input int base, input int n, input int xt, input int ch,
                             input int pu, input int po, input bit cr, input bit nr,
                             input bit mis_close, input string tag);
        for (int i = 0; i < n; i++) begin
            clear_in();
            in_valid       = 1;
            in_pc          = ADDR_W'(base + i);
            in_payload     = PAY_W'((base + i) ^ 16'hA5A5);
            in_taken       = (i == n - 1) || (i >= 1 && i <= xt);
            in_target      = (i == n - 1) ? ADDR_W'(base) : ADDR_W'(base + i + 1);
            in_chunk_start = (i >= 1) && (i < ch);
            in_push        = (i < pu);
            in_pop         = (i < po);
            in_call_ret    = cr && (i == 0);
            in_resident    = !(nr && (i == 0));
            mispredict     = mis_close && (i == n - 1);
            step(tag);
        end
        clear_in();
    endtask

    task automatic try_lock(input int base, input int n, input int xt, input int ch,
                            input int pu, input int po, input bit cr, input bit nr,
                            input string tag);
        do_flush(tag);
        for (int k = 0; k < 3; k++) loop_iter(base, n, xt, ch, pu, po, cr, nr, 0, tag);
        idle(n + 3, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_in();
        m_state = 0; m_cv = 0; m_rd = 0; m_taken = 0; m_chunks = 0; m_bal = 0; m_bad = 0;
        m_cand = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare("R13");
        idle(3, "R13");

        // R1: forward taken branches never become candidates
        send_one(16'h0300, 16'h0310, 1, "R1");
        send_one(16'h0300, 16'h0310, 1, "R1");
        send_one(16'h0300, 16'h0310, 1, "R1");
        idle(2, "R1");
        // R1: a different backward target replaces the candidate
        send_one(16'h0480, 16'h0400, 1, "R1");
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R1");
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R1");
        // R2, R3: this pass is captured and locks, then wraps several times
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R2");
        idle(17, "R3");
        // R12: micro-ops arriving while streaming are ignored
        loop_iter(16'h0200, 4, 0, 1, 0, 0, 0, 0, 0, "R12");
        idle(3, "R12");
        // R10: mispredict ends streaming; candidate kept
        do_mispredict("R10");
        idle(2, "R10");
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R10");
        idle(8, "R10");
        // R12: mispredict and flush cycles ignore their micro-op
        do_mispredict("R12");
        clear_in(); in_valid = 1; in_pc = 16'h0104; in_target = 16'h0100; in_taken = 1;
        flush = 1; step("R12"); clear_in();
        // R11: after flush, two passes are not enough
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R11");
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R11");
        idle(6, "R11");
        loop_iter(16'h0100, 5, 0, 1, 0, 0, 0, 0, 0, "R11");
        idle(6, "R11");

        // collision: closing micro-op with mispredict in the same cycle
        do_flush("R10");
        loop_iter(16'h0500, 6, 0, 1, 0, 0, 0, 0, 0, "R10");
        loop_iter(16'h0500, 6, 0, 1, 0, 0, 0, 0, 0, "R10");
        loop_iter(16'h0500, 6, 0, 1, 0, 0, 0, 0, 1, "R10");
        idle(4, "R10");
        loop_iter(16'h0500, 6, 0, 1, 0, 0, 0, 0, 0, "R10");
        loop_iter(16'h0500, 6, 0, 1, 0, 0, 0, 0, 0, "R10");
        idle(8, "R10");

        // R4: size limit
        try_lock(16'h1000, 64, 0, 1, 0, 0, 0, 0, "R4");
        try_lock(16'h1000, 65, 0, 1, 0, 0, 0, 0, "R4");
        // R5: taken-branch limit
        try_lock(16'h2000, 12, 7, 1, 0, 0, 0, 0, "R5");
        try_lock(16'h2000, 12, 8, 1, 0, 0, 0, 0, "R5");
        // R6: chunk limit
        try_lock(16'h3000, 12, 0, 8, 0, 0, 0, 0, "R6");
        try_lock(16'h3000, 12, 0, 9, 0, 0, 0, 0, "R6");
        // R7: residency
        try_lock(16'h4000, 6, 0, 1, 0, 0, 0, 1, "R7");
        // R8: call or return
        try_lock(16'h5000, 6, 0, 1, 0, 0, 1, 0, "R8");
        // R9: push/pop balance
        try_lock(16'h6000, 6, 0, 1, 2, 1, 0, 0, "R9");
        try_lock(16'h6000, 6, 0, 1, 2, 2, 0, 0, "R9");
        do_flush("R11");
        idle(3, "R11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule